// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block controls one small direct-mapped cache in a system where two or more caches share a single bus and a common memory. Each processor write goes straight through to memory. The same bus transaction also tells every other cache to drop its copy of that block. A read that misses places a read-miss transaction on the bus and fills the line from the memory data returned in the granted cycle.

The controller watches every transaction that another cache puts on the shared bus. When a peer's write names a block it holds, the line is marked invalid, so the next local read of that block misses and fetches the fresh value. Bus access uses a request/grant pair driven by an external fixed-priority arbiter. Only one transaction occupies the bus in any cycle, so all caches see writes to a given location in the same order.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_done` and `bus_req` are low, and the first read of any address misses.
- R2: A read miss raises `bus_req` one cycle after the request is seen. In the granted cycle it drives `bus_cmd` = 1 (read miss) with the request address. It returns the memory word on `cpu_rdata` with `cpu_done` one cycle after the grant, which is two cycles when the grant is immediate. `cpu_done` is a one-cycle pulse.
- R3: A read that hits a valid line with a matching tag completes one cycle after the request, without raising `bus_req`.
- R4: Every write is placed on the bus as `bus_cmd` = 2 (write-invalidate) with address and data, and completes one cycle after its grant. Memory receives the data, and the local line then holds the written value, so a following local read hits.
- R5: A peer write-invalidate to an address held valid in this cache invalidates the line. The next local read of that address misses and returns the newly written value.
- R6: A peer write to an address with the same line index but a different tag leaves the line valid. A following local read hits with the old data.
- R7: A peer read-miss transaction has no effect on this cache's lines.
- R8: If a peer invalidate for a line arrives in the same cycle that a local read would hit that line, the invalidate wins and the read is handled as a miss.
- R9: `bus_req` stays high until granted. When two caches write the same address at once, the lower-numbered one is served first, and both caches then read the later value.
- R10: `bus_cmd` is 0 (idle) in every cycle in which the cache is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant, same cycle |
| bus_cmd | output | 2 | Transaction driven while granted (0 idle, 1 read miss, 2 write-invalidate) |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write data of a write-invalidate |
| snp_cmd | input | 2 | Command currently on the shared bus |
| snp_addr | input | AW | Address currently on the shared bus |
| mem_rdata | input | DW | Memory data for the bus address, same cycle |

## Verification
A hit completes one cycle after the request is taken. A miss or write with an immediate grant completes two cycles after it, and each lost arbitration cycle adds one. The bench drives requests on falling edges and counts the falling edges up to `cpu_done`, then compares that count with the latency the requirement states. This makes the difference between a hit and a miss visible at the ports, which is how invalidation and its absence are observed. The bench captures the bus command in the granted cycle, and starts the same-cycle conflict and simultaneous-write cases at fixed one-cycle offsets so that the snoop lands on the chosen edge.

// File: rtl/snc_pkg.sv
// Shared types for the snooping cache controller.
// Assumes a 2-bit bus command field decoded identically by all caches.
package snc_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_RDMISS = 2'd1,
        BUS_WRINV  = 2'd2
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_RESP = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/snc_line_store.sv
// Direct-mapped line storage: valid bit, tag and data per line.
// Two read ports (local lookup and snoop lookup), one fill port, one
// invalidate port. A fill and an invalidate to the same line on one edge
// cannot occur on a correct bus; should it happen, the fill wins.
module snc_line_store #(
    parameter int IW = 2,
    parameter int TW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] lk_idx,
    output logic          lk_valid,
    output logic [TW-1:0] lk_tag,
    output logic [DW-1:0] lk_data,
    input  logic [IW-1:0] sn_idx,
    output logic          sn_valid,
    output logic [TW-1:0] sn_tag,
    input  logic          fill_en,
    input  logic [IW-1:0] fill_idx,
    input  logic [TW-1:0] fill_tag,
    input  logic [DW-1:0] fill_data,
    input  logic          inv_en,
    input  logic [IW-1:0] inv_idx
);
    localparam int LINES = 1 << IW;

    logic          valid_q [LINES];
    logic [TW-1:0] tag_q   [LINES];
    logic [DW-1:0] data_q  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line state: snoop invalidate, then local fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
                data_q[g]  <= '0;
            end else begin
                if (inv_en && inv_idx == IW'(g)) valid_q[g] <= 1'b0;
                if (fill_en && fill_idx == IW'(g)) begin
                    valid_q[g] <= 1'b1;
                    tag_q[g]   <= fill_tag;
                    data_q[g]  <= fill_data;
                end
            end
        end
    end

    // Lookup ports are purely combinational.
    always_comb begin
        lk_valid = valid_q[lk_idx];
        lk_tag   = tag_q[lk_idx];
        lk_data  = data_q[lk_idx];
        sn_valid = valid_q[sn_idx];
        sn_tag   = tag_q[sn_idx];
    end
endmodule

// File: rtl/snc_snoop.sv
// Snoop filter: decides whether the transaction currently on the shared
// bus must invalidate one of this cache's lines. Only peer write-invalidates
// count; the cache's own granted transaction is never snooped.
module snc_snoop #(
    parameter int AW = 8,
    parameter int IW = 2
) (
    input  logic [1:0]       snp_cmd,
    input  logic [AW-1:0]    snp_addr,
    input  logic             own_gnt,
    output logic [IW-1:0]    sn_idx,
    input  logic             sn_valid,
    input  logic [AW-IW-1:0] sn_tag,
    output logic             inv_en
);
    import snc_pkg::*;

    // Tag compare on the line the bus address indexes.
    always_comb begin
        sn_idx = snp_addr[IW-1:0];
        inv_en = (bus_cmd_e'(snp_cmd) == BUS_WRINV) && !own_gnt
                 && sn_valid && (sn_tag == snp_addr[AW-1:IW]);
    end
endmodule

// File: rtl/snc_ctrl_fsm.sv
// Request sequencer: IDLE takes a processor request, BUS waits for the
// grant and issues the transaction, RESP signals completion for one cycle.
// Assumes the processor holds its request steady until completion.
module snc_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic lk_hit,
    input  logic conflict,
    input  logic bus_gnt,
    output logic in_bus,
    output logic in_resp,
    output logic hit_take,
    output logic issue
);
    import snc_pkg::*;

    ctl_state_e state_q, state_d;

    // Hit decision and bus issue strobes.
    always_comb begin
        hit_take = (state_q == ST_IDLE) && cpu_req && !cpu_we && lk_hit && !conflict;
        issue    = (state_q == ST_BUS) && bus_gnt;
        in_bus   = (state_q == ST_BUS);
        in_resp  = (state_q == ST_RESP);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cpu_req) state_d = hit_take ? ST_RESP : ST_BUS;
            ST_BUS:  if (bus_gnt) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bus && !bus_gnt) |=> in_bus); // R9
    AST_CONFLICT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !cpu_we && conflict) |=> in_bus); // R8
endmodule

// File: rtl/snoop_cache_ctrl.sv
// Write-through, write-invalidate snooping cache controller for one
// direct-mapped cache. Reads hit locally or fetch from memory over the bus;
// writes always go over the bus, updating memory and invalidating peers.
// Assumes an external fixed-priority arbiter, memory data returned in the
// granted cycle, and snp_* carrying whatever is on the shared bus.
module snoop_cache_ctrl #(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_done,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] mem_rdata
);
    import snc_pkg::*;

    localparam int TW = AW - IW;

    logic [IW-1:0] cpu_idx, sn_idx;
    logic [TW-1:0] cpu_tag, lk_tag, sn_tag;
    logic          lk_valid, sn_valid, lk_hit, inv_en, conflict;
    logic [DW-1:0] lk_data, fill_data, rdata_q;
    logic          in_bus, in_resp, hit_take, issue;

    // Address split and hit/conflict detection.
    always_comb begin
        cpu_idx   = cpu_addr[IW-1:0];
        cpu_tag   = cpu_addr[AW-1:IW];
        lk_hit    = lk_valid && (lk_tag == cpu_tag);
        conflict  = inv_en && (sn_idx == cpu_idx);
        fill_data = cpu_we ? cpu_wdata : mem_rdata;
    end

    snc_line_store #(.IW(IW), .TW(TW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (cpu_idx),
        .lk_valid (lk_valid),
        .lk_tag   (lk_tag),
        .lk_data  (lk_data),
        .sn_idx   (sn_idx),
        .sn_valid (sn_valid),
        .sn_tag   (sn_tag),
        .fill_en  (issue),
        .fill_idx (cpu_idx),
        .fill_tag (cpu_tag),
        .fill_data(fill_data),
        .inv_en   (inv_en),
        .inv_idx  (sn_idx)
    );

    snc_snoop #(.AW(AW), .IW(IW)) u_snoop (
        .snp_cmd (snp_cmd),
        .snp_addr(snp_addr),
        .own_gnt (bus_gnt),
        .sn_idx  (sn_idx),
        .sn_valid(sn_valid),
        .sn_tag  (sn_tag),
        .inv_en  (inv_en)
    );

    snc_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_req (cpu_req),
        .cpu_we  (cpu_we),
        .lk_hit  (lk_hit),
        .conflict(conflict),
        .bus_gnt (bus_gnt),
        .in_bus  (in_bus),
        .in_resp (in_resp),
        .hit_take(hit_take),
        .issue   (issue)
    );

    // Bus drive: only while granted.
    always_comb begin
        bus_req   = in_bus;
        bus_cmd   = issue ? (cpu_we ? BUS_WRINV : BUS_RDMISS) : BUS_IDLE;
        bus_addr  = issue ? cpu_addr : '0;
        bus_wdata = (issue && cpu_we) ? cpu_wdata : '0;
    end

    // Read data capture on hit or on the granted bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (hit_take) rdata_q <= lk_data;
        else if (issue)    rdata_q <= fill_data;
    end

    assign cpu_rdata = rdata_q;
    assign cpu_done  = in_resp;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done); // R2
    AST_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_cmd == BUS_WRINV) |=> cpu_done); // R4
    AST_WRITE_USES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_done) && !$past(bus_req)) |-> !cpu_we); // R4
    AST_CMD_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_gnt |-> (bus_cmd == BUS_IDLE)); // R10
endmodule

// File: tb/snoop_cache_ctrl_tb.sv
// Two caches, a fixed-priority arbiter (cache 0 first) and a memory model.
module snoop_cache_ctrl_tb;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int IW = 2;
    localparam int MEMW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req   [2];
    logic          we    [2];
    logic [AW-1:0] addr  [2];
    logic [DW-1:0] wdata [2];
    logic [DW-1:0] rdata [2];
    logic          done  [2];
    logic          breq  [2];
    logic          gnt   [2];
    logic [1:0]    bcmd  [2];
    logic [AW-1:0] baddr [2];
    logic [DW-1:0] bwd   [2];

    logic [1:0]    shd_cmd;
    logic [AW-1:0] shd_addr;
    logic [DW-1:0] shd_wdata;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem [MEMW];
    logic [DW-1:0] exp_mem [MEMW];

    int checks = 0;
    int fails  = 0;
    int wd     = 0;

    // Fixed-priority arbitration and shared bus mux.
    always_comb begin
        gnt[0] = breq[0];
        gnt[1] = breq[1] && !breq[0];
        shd_cmd   = gnt[0] ? bcmd[0]  : gnt[1] ? bcmd[1]  : 2'd0;
        shd_addr  = gnt[0] ? baddr[0] : gnt[1] ? baddr[1] : '0;
        shd_wdata = gnt[0] ? bwd[0]   : gnt[1] ? bwd[1]   : '0;
    end
    assign mem_rdata = mem[shd_addr];

    // Memory model: write-invalidate updates the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMW; i++) mem[i] <= DW'(i * 3 + 1);
        end else if (shd_cmd == 2'd2) begin
            mem[shd_addr] <= shd_wdata;
        end
    end

    snoop_cache_ctrl #(.AW(AW), .DW(DW), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(addr[0]), .cpu_wdata(wdata[0]),
        .cpu_rdata(rdata[0]), .cpu_done(done[0]),
        .bus_req(breq[0]), .bus_gnt(gnt[0]), .bus_cmd(bcmd[0]), .bus_addr(baddr[0]),
        .bus_wdata(bwd[0]), .snp_cmd(shd_cmd), .snp_addr(shd_addr), .mem_rdata(mem_rdata)
    );

    snoop_cache_ctrl #(.AW(AW), .DW(DW), .IW(IW)) u_peer (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]), .cpu_wdata(wdata[1]),
        .cpu_rdata(rdata[1]), .cpu_done(done[1]),
        .bus_req(breq[1]), .bus_gnt(gnt[1]), .bus_cmd(bcmd[1]), .bus_addr(baddr[1]),
        .bus_wdata(bwd[1]), .snp_cmd(shd_cmd), .snp_addr(shd_addr), .mem_rdata(mem_rdata)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One processor access; returns data, cycles to done and granted command.
    task automatic op(int c, bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                      output logic [DW-1:0] rd, output int cyc,
                      output logic [1:0] cmd, output logic [AW-1:0] cad);
        @(negedge clk);
        req[c] = 1'b1; we[c] = w; addr[c] = a; wdata[c] = d;
        cyc = 0; cmd = 2'd0; cad = '0; rd = '0;
        while (cyc < 50) begin
            @(negedge clk);
            cyc++;
            if (gnt[c]) begin cmd = bcmd[c]; cad = baddr[c]; end
            if (done[c]) break;
        end
        rd = rdata[c];
        req[c] = 1'b0; we[c] = 1'b0;
        if (w) exp_mem[a] = d;
    endtask

    // R10: no command while not granted, watched on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                if (!gnt[c] && bcmd[c] != 2'd0) begin
                    fails++;
                    $display("FAIL R10: cache %0d cmd=%0d expected=0 without grant", c, bcmd[c]);
                end
            end
        end
    end

    task automatic t_reset();
        chk("R1 done0", int'(done[0]), 0);
        chk("R1 breq0", int'(breq[0]), 0);
        chk("R1 breq1", int'(breq[1]), 0);
    endtask

    task automatic t_read_miss_hit();
        logic [DW-1:0] rd; int cyc; logic [1:0] cmd; logic [AW-1:0] ca;
        op(0, 1'b0, 8'h05, 8'h00, rd, cyc, cmd, ca);
        chk("R1 R2 miss latency", cyc, 2);
        chk("R2 bus cmd", int'(cmd), 1);
        chk("R2 bus addr", int'(ca), 8'h05);
        chk("R2 data", int'(rd), int'(exp_mem[8'h05]));
        op(0, 1'b0, 8'h05, 8'h00, rd, cyc, cmd, ca);
        chk("R3 hit latency", cyc, 1);
        chk("R3 no bus", int'(cmd), 0);
        chk("R3 data", int'(rd), int'(exp_mem[8'h05]));
    endtask

    task automatic t_write();
        logic [DW-1:0] rd; int cyc; logic [1:0] cmd; logic [AW-1:0] ca;
        op(0, 1'b1, 8'h05, 8'hA7, rd, cyc, cmd, ca);
        chk("R4 write latency", cyc, 2);
        chk("R4 bus cmd", int'(cmd), 2);
        chk("R4 bus addr", int'(ca), 8'h05);
        chk("R4 memory", int'(mem[8'h05]), 8'hA7);
        op(0, 1'b0, 8'h05, 8'h00, rd, cyc, cmd, ca);
        chk("R4 local hit latency", cyc, 1);
        chk("R4 local data", int'(rd), 8'hA7);
    endtask

    task automatic t_invalidate();
        logic [DW-1:0] rd; int cyc; logic [1:0] cmd; logic [AW-1:0] ca;
        op(1, 1'b0, 8'h09, 8'h00, rd, cyc, cmd, ca);
        chk("R5 fill peer", int'(rd), int'(exp_mem[8'h09]));
        op(0, 1'b1, 8'h09, 8'h3C, rd, cyc, cmd, ca);
        op(1, 1'b0, 8'h09, 8'h00, rd, cyc, cmd, ca);
        chk("R5 reread misses", cyc, 2);
        chk("R5 fresh data", int'(rd), 8'h3C);
    endtask

    task automatic t_other_tag();
        logic [DW-1:0] rd; int cyc; logic [1:0] cmd; logic [AW-1:0] ca;
        op(0, 1'b0, 8'h11, 8'h00, rd, cyc, cmd, ca);
        op(1, 1'b1, 8'h15, 8'h6B, rd, cyc, cmd, ca);
        op(0, 1'b0, 8'h11, 8'h00, rd, cyc, cmd, ca);
        chk("R6 still hits", cyc, 1);
        chk("R6 old data", int'(rd), int'(exp_mem[8'h11]));
    endtask

    task automatic t_peer_read();
        logic [DW-1:0] rd; int cyc; logic [1:0] cmd; logic [AW-1:0] ca;
        op(0, 1'b0, 8'h22, 8'h00, rd, cyc, cmd, ca);
        op(1, 1'b0, 8'h22, 8'h00, rd, cyc, cmd, ca);
        chk("R7 peer miss on bus", int'(cmd), 1);
        op(0, 1'b0, 8'h22, 8'h00, rd, cyc, cmd, ca);
        chk("R7 still hits", cyc, 1);
        chk("R7 data", int'(rd), int'(exp_mem[8'h22]));
    endtask

    task automatic t_conflict();
        logic [DW-1:0] r0, r1; int c0, c1; logic [1:0] m0, m1; logic [AW-1:0] a0, a1;
        op(1, 1'b0, 8'h2E, 8'h00, r1, c1, m1, a1);
        chk("R8 line loaded", c1, 2);
        fork
            op(0, 1'b1, 8'h2E, 8'hD4, r0, c0, m0, a0);
            begin
                @(negedge clk);
                op(1, 1'b0, 8'h2E, 8'h00, r1, c1, m1, a1);
            end
        join
        chk("R8 read treated as miss", c1, 2);
        chk("R8 read data new", int'(r1), 8'hD4);
    endtask

    task automatic t_race();
        logic [DW-1:0] r0, r1; int c0, c1; logic [1:0] m0, m1; logic [AW-1:0] a0, a1;
        fork
            op(0, 1'b1, 8'h33, 8'h81, r0, c0, m0, a0);
            op(1, 1'b1, 8'h33, 8'h92, r1, c1, m1, a1);
        join
        exp_mem[8'h33] = 8'h92;
        chk("R9 cache0 first", c0, 2);
        chk("R9 cache1 waits", c1, 3);
        chk("R9 memory final", int'(mem[8'h33]), 8'h92);
        op(0, 1'b0, 8'h33, 8'h00, r0, c0, m0, a0);
        op(1, 1'b0, 8'h33, 8'h00, r1, c1, m1, a1);
        chk("R9 cache0 sees final", int'(r0), 8'h92);
        chk("R9 cache1 sees final", int'(r1), 8'h92);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            fails++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("test done: total=%0d bad=%0d", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            req[c] = 1'b0; we[c] = 1'b0; addr[c] = '0; wdata[c] = '0;
        end
        for (int i = 0; i < MEMW; i++) exp_mem[i] = DW'(i * 3 + 1);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss_hit();
        t_write();
        t_invalidate();
        t_other_tag();
        t_peer_read();
        t_conflict();
        t_race();
        chk("R10 monitor ran", 1, 1);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule